// File: doc/BRIEF.md
# Eight-Bit Waveform Timer with Two Compare Channels

This block is an 8-bit timer/counter that advances once per cycle in which the external prescaler raises its one-cycle `tick` enable. Two output-compare channels, A and B, compare the counter with their own compare values. On a match they set a sticky flag and drive a waveform pin. The counter runs in one of four modes. Normal mode counts up and wraps. Clear-on-compare (CTC) mode counts up and restarts from zero after matching channel A. Fast PWM counts on a single slope from 0 to 255. Phase-correct PWM counts up to 255 and back down to 0.

Software reaches the block through a single-cycle write bus. It can write the counter, either compare value, the control word, or a flag-clear mask. In the two PWM modes a compare write lands in a buffer and is copied into the active register only when the count leaves 255. In normal and CTC mode the write takes effect at once. A counter write suppresses compare matches on the next tick. A pair of force strobes applies a channel's match action to its pin without a real match, and only in the non-PWM modes.

The count direction is held in a two-state machine with the states DIR_UP and DIR_DOWN. In phase-correct mode the machine takes two transitions. The turn-down transition goes from DIR_UP to DIR_DOWN when the counter steps onto 255. The turn-up transition goes from DIR_DOWN to DIR_UP when it steps onto 0. In every other mode a forced-up transition holds the machine in DIR_UP.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, both waveform pins are 0, all three flags are 0 and the mode is normal.
- R2: A write with `wr_en` high acts at the next clock edge. `wr_sel` picks the target: 0 counter, 1 compare A, 2 compare B, 3 control, 4 flag clear. Control bits [1:0] select the mode (0 normal, 1 CTC, 2 fast PWM, 3 phase-correct). Bits [3:2] are the output mode of A and bits [5:4] the output mode of B. A counter write takes priority over a coincident tick.
- R3: In normal and fast PWM mode each tick adds one, wrapping 255 to 0. In normal, CTC and fast PWM mode the overflow flag sets on a tick taken while the count is 255.
- R4: In CTC mode a tick taken while the count equals the active compare A value, and not blocked, reloads the count with 0, so the period is A+1 ticks.
- R5: In phase-correct mode the count climbs to 255 and then falls to 0, for a period of 510 ticks. The overflow flag sets on a tick taken while the count is 0.
- R6: In normal and CTC mode a compare write updates the active value immediately. In the PWM modes it only fills a buffer, which is copied into the active value on a tick taken while the count is 255.
- R7: A counter write blocks all compare matches, including the CTC restart, on the first tick after it, however many idle cycles pass before that tick.
- R8: A compare match is a tick, not blocked, taken while the count equals that channel's active value. It sets the channel flag (bit 1 for A, bit 2 for B; bit 0 is overflow). Flags stay set until a flag-clear write with a one in their bit. A set in the same cycle beats the clear.
- R9: In normal and CTC mode a match drives the pin per its output mode: 0 holds, 1 toggles, 2 drives 0, 3 drives 1.
- R10: In fast PWM, output mode 2 drives the pin 0 on a match and 1 on a tick at 255, and the 255 action wins when both occur. Output mode 3 is the inverse. Modes 0 and 1 hold the pin.
- R11: In phase-correct mode, output mode 2 drives the pin 0 on a match while counting up and 1 on a match while counting down. Output mode 3 does the opposite. Modes 0 and 1 hold the pin.
- R12: `force_a`/`force_b` in normal or CTC mode apply that channel's match action to its pin. They set no flag and leave the count unchanged. In the PWM modes they have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| force_a | input | 1 | Force-compare strobe, channel A |
| force_b | input | 1 | Force-compare strobe, channel B |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Waveform pin, channel A |
| wave_b | output | 1 | Waveform pin, channel B |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_a_flag | output | 1 | Sticky compare flag, channel A |
| match_b_flag | output | 1 | Sticky compare flag, channel B |

## Verification
The assertions watch several local rules on every cycle:
- the one-step advance in normal mode and the one-step descent in phase-correct mode;
- that no match follows a counter write and that a blocked CTC tick never restarts the count;
- that the active compare value is frozen between load points in PWM modes;
- that flags stay sticky;
- that a match toggles the pin in toggle mode;
- that a force in a PWM mode leaves the pin alone.

Only the bench's scenarios can show the longer behaviour:
- the full mode periods and the exact count after hundreds of ticks;
- that a buffered compare value really takes over on the tick after the wrap;
- the up-match and down-match pin actions of phase-correct mode;
- that a force in CTC mode moves the pin without touching count or flag.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tmr_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    typedef enum logic [2:0] {
        SEL_COUNT = 3'd0,
        SEL_CMPA  = 3'd1,
        SEL_CMPB  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_FLAGS = 3'd4
    } wsel_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] top_a,
    output logic [W-1:0] cnt_q,
    output dir_state_e   dir_q,
    output logic         cmp_ok,
    output logic         at_max,
    output logic         at_min
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    dir_state_e   dir_d;
    logic [W-1:0] cnt_d;
    logic [W-1:0] inc;
    logic [W-1:0] dec;
    logic         block_q;

    assign inc    = cnt_q + ONE;
    assign dec    = cnt_q - ONE;
    assign at_max = (cnt_q == MAXV);
    assign at_min = (cnt_q == '0);
    assign cmp_ok = tick && !block_q;

    // next-state and next-count logic
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (mode != MODE_PHASE) begin
            dir_d = DIR_UP;
        end
        if (cnt_wr) begin
            cnt_d = wr_data;
        end else if (tick) begin
            unique case (mode)
                MODE_NORMAL, MODE_FAST: cnt_d = inc;
                MODE_CTC: cnt_d = (!block_q && cnt_q == top_a) ? '0 : inc;
                MODE_PHASE: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (at_max) begin
                                cnt_d = MAXV - ONE;
                                dir_d = DIR_DOWN;
                            end else begin
                                cnt_d = inc;
                                if (inc == MAXV) dir_d = DIR_DOWN;
                            end
                        end
                        DIR_DOWN: begin
                            if (at_min) begin
                                cnt_d = ONE;
                                dir_d = DIR_UP;
                            end else begin
                                cnt_d = dec;
                                if (dec == '0) dir_d = DIR_UP;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= DIR_UP;
        else        dir_q <= dir_d;
    end

    // count and match-block registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            block_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cnt_wr)    block_q <= 1'b1;
            else if (tick) block_q <= 1'b0;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && mode == MODE_NORMAL) |=> cnt_q == $past(cnt_q) + ONE);

    // R5
    phase_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PHASE && dir_q == DIR_DOWN && tick && !cnt_wr && !at_min)
        |=> cnt_q == $past(cnt_q) - ONE);

    // R7
    ctc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_q && tick && !cnt_wr && mode == MODE_CTC && !at_max) |=> cnt_q != '0);

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_mode_e    mode,
    input  logic [1:0]   out_mode,
    input  logic         cmp_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         cmp_ok,
    input  logic         max_tick,
    input  dir_state_e   dir,
    input  logic         force_in,
    output logic         wave_q,
    output logic         match_evt,
    output logic [W-1:0] act_q
);
    logic [W-1:0] buf_q;
    logic         is_pwm;
    logic         load;
    logic         wave_d;
    logic         hit;

    assign is_pwm    = (mode == MODE_FAST) || (mode == MODE_PHASE);
    assign match_evt = cmp_ok && (cnt == act_q);
    assign load      = is_pwm && max_tick;
    assign hit       = match_evt || force_in;

    // compare value storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (cmp_wr) buf_q <= wr_data;
            if (cmp_wr && !is_pwm) act_q <= wr_data;
            else if (load)         act_q <= buf_q;
        end
    end

    // waveform next value
    always_comb begin
        wave_d = wave_q;
        unique case (mode)
            MODE_NORMAL, MODE_CTC: begin
                if (hit) begin
                    unique case (out_mode)
                        2'd0: wave_d = wave_q;
                        2'd1: wave_d = !wave_q;
                        2'd2: wave_d = 1'b0;
                        2'd3: wave_d = 1'b1;
                    endcase
                end
            end
            MODE_FAST: begin
                if (out_mode[1]) begin
                    if (max_tick)       wave_d = !out_mode[0];
                    else if (match_evt) wave_d = out_mode[0];
                end
            end
            MODE_PHASE: begin
                if (out_mode[1] && match_evt) begin
                    wave_d = (dir == DIR_DOWN) ^ out_mode[0];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !load) |=> $stable(act_q));

    // R12
    pwm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && force_in && !max_tick && !match_evt) |=> $stable(wave_q));

    // R9
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && out_mode == 2'd1 && match_evt) |=> wave_q != $past(wave_q));

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             force_a,
    input  logic             force_b,
    output logic [CNT_W-1:0] count,
    output logic             wave_a,
    output logic             wave_b,
    output logic             ovf_flag,
    output logic             match_a_flag,
    output logic             match_b_flag
);
    localparam int unsigned NFLAG = NUM_CH + 1;

    tmr_mode_e        mode_q;
    logic [1:0]       om_q   [NUM_CH];
    logic             frc    [NUM_CH];
    logic             cwr    [NUM_CH];
    logic             wave   [NUM_CH];
    logic             mevt   [NUM_CH];
    logic [CNT_W-1:0] act    [NUM_CH];

    logic             cnt_wr;
    logic             ctrl_wr;
    logic             flag_wr;
    logic [CNT_W-1:0] cnt_q;
    dir_state_e       dir_q;
    logic             cmp_ok;
    logic             at_max;
    logic             at_min;
    logic             max_tick;
    logic             ovf_set;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;

    assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign flag_wr = wr_en && (wr_sel == SEL_FLAGS);
    assign cwr[0]  = wr_en && (wr_sel == SEL_CMPA);
    assign cwr[1]  = wr_en && (wr_sel == SEL_CMPB);
    assign frc[0]  = force_a;
    assign frc[1]  = force_b;

    // control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_NORMAL;
            om_q[0]  <= 2'd0;
            om_q[1]  <= 2'd0;
        end else if (ctrl_wr) begin
            mode_q   <= tmr_mode_e'(wr_data[1:0]);
            om_q[0]  <= wr_data[3:2];
            om_q[1]  <= wr_data[5:4];
        end
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode_q),
        .cnt_wr  (cnt_wr),
        .wr_data (wr_data),
        .top_a   (act[0]),
        .cnt_q   (cnt_q),
        .dir_q   (dir_q),
        .cmp_ok  (cmp_ok),
        .at_max  (at_max),
        .at_min  (at_min)
    );

    assign max_tick = tick && at_max;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_cmp_chan #(.W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_q),
            .out_mode  (om_q[c]),
            .cmp_wr    (cwr[c]),
            .wr_data   (wr_data),
            .cnt       (cnt_q),
            .cmp_ok    (cmp_ok),
            .max_tick  (max_tick),
            .dir       (dir_q),
            .force_in  (frc[c]),
            .wave_q    (wave[c]),
            .match_evt (mevt[c]),
            .act_q     (act[c])
        );
        assign flag_set[c+1] = mevt[c];
        assign flag_clr[c+1] = flag_wr && wr_data[c+1];
    end

    assign ovf_set     = tick && ((mode_q == MODE_PHASE) ? at_min : at_max);
    assign flag_set[0] = ovf_set;
    assign flag_clr[0] = flag_wr && wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | flag_set;
    end

    assign count        = cnt_q;
    assign wave_a       = wave[0];
    assign wave_b       = wave[1];
    assign ovf_flag     = flag_q[0];
    assign match_a_flag = flag_q[1];
    assign match_b_flag = flag_q[2];

    // R7
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !mevt[0] && !mevt[1]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a_flag && !(flag_wr && wr_data[1])) |=> match_a_flag);

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_q != MODE_PHASE && count == {CNT_W{1'b1}}) |=> ovf_flag);

endmodule

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       force_a = 1'b0;
    logic       force_b = 1'b0;
    logic [7:0] count;
    logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwm_timer8 uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .force_a(force_a), .force_b(force_b), .count(count),
        .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
        .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
    );

    // {mode[34:33], cmp_a[32:25], ticks[24:9], exp_count[8:1], exp_ovf[0]}
    localparam int NV = 7;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 8'h00, 16'd10,  8'd10,  1'b0},
        {2'd0, 8'h00, 16'd300, 8'd44,  1'b1},
        {2'd1, 8'h09, 16'd25,  8'd5,   1'b0},
        {2'd1, 8'h00, 16'd3,   8'd3,   1'b0},
        {2'd2, 8'h00, 16'd263, 8'd7,   1'b1},
        {2'd3, 8'h80, 16'd300, 8'd210, 1'b1},
        {2'd3, 8'h80, 16'd520, 8'd10,  1'b1}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse(input logic fa, input logic fb);
        @(negedge clk);
        force_a = fa; force_b = fb;
        @(negedge clk);
        force_a = 1'b0; force_b = 1'b0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(16'(count), 16'h0, "R1 count");
        chk(16'({wave_a, wave_b}), 16'h0, "R1 waves");
        chk(16'({ovf_flag, match_a_flag, match_b_flag}), 16'h0, "R1 flags");

        // table walk over the four counting modes
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VEC[i][34:33])
                2'd0: tag = "R3 normal";
                2'd1: tag = (i == 3) ? "R7 ctc-block" : "R4 ctc";
                2'd2: tag = "R3 fast";
                default: tag = "R5 phase";
            endcase
            wr(3'd3, 8'h00);
            wr(3'd3, {6'd0, VEC[i][34:33]});
            wr(3'd1, VEC[i][32:25]);
            wr(3'd0, 8'h00);
            wr(3'd4, 8'h07);
            run(int'(VEC[i][24:9]));
            chk(16'(count), 16'(VEC[i][8:1]), tag);
            chk(16'(ovf_flag), 16'(VEC[i][0]), tag);
        end

        // counter-write block across idle cycles, immediate compare, toggle
        wr(3'd3, 8'h10);
        wr(3'd2, 8'h05);
        wr(3'd0, 8'h05);
        chk(16'(count), 16'h05, "R2 counter write");
        wr(3'd4, 8'h07);
        repeat (3) @(negedge clk);
        run(1);
        chk(16'(count), 16'h06, "R7 count after blocked tick");
        chk(16'(match_b_flag), 16'h0, "R7 blocked match flag");
        chk(16'(wave_b), 16'h0, "R7 blocked match pin");
        wr(3'd2, 8'h07);
        run(1);
        chk(16'(match_b_flag), 16'h0, "R6 no early match");
        run(1);
        chk(16'(match_b_flag), 16'h1, "R6 immediate compare");
        chk(16'(wave_b), 16'h1, "R9 toggle on match");
        wr(3'd4, 8'h02);
        chk(16'(match_b_flag), 16'h1, "R8 other bit keeps flag");
        wr(3'd4, 8'h04);
        chk(16'(match_b_flag), 16'h0, "R8 clear flag");

        // force strobes
        pulse(1'b0, 1'b1);
        chk(16'(wave_b), 16'h0, "R12 force toggles");
        chk(16'(match_b_flag), 16'h0, "R12 force no flag");
        pulse(1'b0, 1'b1);
        wr(3'd3, 8'h22);
        pulse(1'b0, 1'b1);
        chk(16'(wave_b), 16'h1, "R12 force ignored in pwm");
        wr(3'd3, 8'h05);
        wr(3'd1, 8'h30);
        wr(3'd0, 8'h30);
        wr(3'd4, 8'h07);
        pulse(1'b1, 1'b0);
        chk(16'(wave_a), 16'h1, "R12 ctc force pin");
        chk(16'(count), 16'h30, "R12 ctc force keeps count");
        chk(16'(match_a_flag), 16'h0, "R12 ctc force no flag");

        // fast PWM buffering and waveform
        wr(3'd3, 8'h0A);
        wr(3'd1, 8'h20);
        wr(3'd0, 8'h10);
        wr(3'd4, 8'h07);
        run(17);
        chk(16'(count), 16'h21, "R6 fast count");
        chk(16'(match_a_flag), 16'h0, "R6 buffered value not active");
        chk(16'(wave_a), 16'h1, "R6 pin unchanged");
        run(16);
        chk(16'(wave_a), 16'h0, "R10 clear on old match");
        chk(16'(match_a_flag), 16'h1, "R10 old match flag");
        wr(3'd4, 8'h07);
        run(207);
        chk(16'(count), 16'h00, "R10 wrap count");
        chk(16'(wave_a), 16'h1, "R10 set at top");
        run(33);
        chk(16'(wave_a), 16'h0, "R6 new value active");
        chk(16'(match_a_flag), 16'h1, "R6 new match flag");

        // phase-correct waveform
        wr(3'd3, 8'h2C);
        pulse(1'b1, 1'b1);
        wr(3'd1, 8'h40);
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h3B);
        wr(3'd0, 8'h00);
        run(64);
        chk(16'(count), 16'h40, "R5 phase up count");
        chk(16'({wave_a, wave_b}), 16'h2, "R11 before up match");
        run(1);
        chk(16'({wave_a, wave_b}), 16'h1, "R11 up match");
        run(381);
        chk(16'(count), 16'h40, "R5 phase down count");
        chk(16'({wave_a, wave_b}), 16'h1, "R11 before down match");
        run(1);
        chk(16'({wave_a, wave_b}), 16'h2, "R11 down match");
        chk(16'(count), 16'h3F, "R5 descending");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule